// File: doc/BRIEF.md
# Burst-of-Two Common-IO SRAM Device Controller

This block is the control logic that sits behind the pins of a synchronous SRAM with a shared data bus and a fixed burst length of two. A command is taken on the rising edge of the command clock while the active-low load strobe is low. The read/write level picks the operation and the address selects the first location of the pair. Every command moves exactly two words. The second word sits at the location whose lowest address bit is the inverse of the first one.

Write data arrives late. The first word is sampled on the rising edge one cycle after the command, and the second on the falling edge that follows. Both words, each with its own per-lane byte enables, wait in a deferred write stage and are committed to the array on the next rising edge. Read data leaves on a half-cycle grid. The first word is driven from the falling edge 1.5 cycles after the command, and the second from the rising edge 2 cycles after it. The output enable goes low by itself whenever no read word is on the bus. A read that arrives while a write is still pending takes the pending bytes, so it always sees the newest data.

The tri-state bus is modelled as separate write data, read data and output enable signals. The storage is a small register array whose depth and word layout are set by parameters.

Top module: `b2_sram_core`

## Requirements
- R1: A command is accepted only on a rising clock edge with `ld_ni` low: `rw_i` = 1 selects a read and `rw_i` = 0 selects a write. With `ld_ni` high the address, direction and write data are ignored and the array is left unchanged.
- R2: For a read accepted at edge T, `oe_o` is 1 and `rdata_o` carries the first word during the low clock phase that starts at T+1.5. It carries the second word during the high phase that starts at T+2.
- R3: For a write accepted at edge T, the first word and its enables are sampled at the rising edge T+1, and the second word and its enables at the falling edge T+1.5.
- R4: The first word of a burst uses location A and the second uses location A XOR 1, for both even and odd A.
- R5: Idle cycles (`ld_ni` high) that follow a read do not stop or change that read's two output words.
- R6: Whenever no read word is being driven, `oe_o` is 0 and `rdata_o` is all zeros.
- R7: Bit i of `wbe_i` enables lane i (bits [i*LANE_W +: LANE_W]) of the word being sampled. Lanes whose enable is 0 keep their stored value. Each of the two words uses the enables sampled with it.
- R8: A read accepted in the cycle right after a write to an overlapping location returns the merged new bytes of that write.
- R9: Reads accepted on consecutive cycles produce an unbroken stream of words with `oe_o` held at 1.
- R10: While `rst_ni` is low, `oe_o` is 0 and `rdata_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock; both edges are used for data |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ni | input | 1 | Load strobe, active low; low accepts a command |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ADDR_W | Location of the first word of the burst |
| wbe_i | input | LANES | Lane write enables, sampled with each write word |
| wdata_i | input | LANES*LANE_W | Write data, sampled on the late-write edges |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| oe_o | output | 1 | Output enable of the shared bus |

## Verification
The assertions assume that `ld_ni`, `rw_i` and `addr_i` are stable and known around each rising edge. They also assume that `wdata_i` and `wbe_i` are stable around both edges of the cycle after a write. The bench drives all inputs at points 2 ns away from either edge and changes write data only between the two sampling edges, so no input moves near a sampling edge. The bench writes every location before it reads it, because the array itself has no reset value.

// File: rtl/b2_sram_pkg.sv
`timescale 1ns/1ps
package b2_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/b2_cmd_ctrl.sv
`timescale 1ns/1ps
module b2_cmd_ctrl
  import b2_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_ni,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [LANES-1:0]  wbe_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              wa_vld_o,
  output logic [ADDR_W-1:0] wa_addr_o,
  output logic [W-1:0]      wa_d0_o,
  output logic [LANES-1:0]  wa_be0_o,
  output logic [W-1:0]      wa_d1_o,
  output logic [LANES-1:0]  wa_be1_o
);
  op_e               op_q;
  logic [ADDR_W-1:0] cmd_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_IDLE;
      cmd_addr_q <= '0;
    end else if (!ld_ni) begin
      op_q       <= rw_i ? OP_READ : OP_WRITE;
      cmd_addr_q <= addr_i;
    end else begin
      op_q       <= OP_IDLE;
    end
  end

  // late write: beat 0 on the next rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_vld_o  <= 1'b0;
      wa_addr_o <= '0;
      wa_d0_o   <= '0;
      wa_be0_o  <= '0;
    end else begin
      wa_vld_o <= (op_q == OP_WRITE);
      if (op_q == OP_WRITE) begin
        wa_addr_o <= cmd_addr_q;
        wa_d0_o   <= wdata_i;
        wa_be0_o  <= wbe_i;
      end
    end
  end

  // beat 1 on the falling edge half a cycle later
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wa_d1_o  <= '0;
      wa_be1_o <= '0;
    end else if (wa_vld_o) begin
      wa_d1_o  <= wdata_i;
      wa_be1_o <= wbe_i;
    end
  end

  assign op_o       = op_q;
  assign cmd_addr_o = cmd_addr_q;

  AST_IDLE_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |=> (op_q == OP_IDLE)); // R1
  AST_WR_BEAT0_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_WRITE) |=> (wa_vld_o && wa_d0_o == $past(wdata_i))); // R3
endmodule

// File: rtl/b2_array.sv
`timescale 1ns/1ps
module b2_array #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wa_vld_i,
  input  logic [ADDR_W-1:0] wa_addr_i,
  input  logic [W-1:0]      wa_d0_i,
  input  logic [LANES-1:0]  wa_be0_i,
  input  logic [W-1:0]      wa_d1_i,
  input  logic [LANES-1:0]  wa_be1_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_vld_o,
  output logic [W-1:0]      rd_w0_o,
  output logic [W-1:0]      rd_w1_o
);
  logic [W-1:0]      mem_q [DEPTH];
  logic [ADDR_W-1:0] wa_addr1;
  logic [W-1:0]      fwd [2];

  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_w,
                                              input logic [W-1:0] new_w,
                                              input logic [LANES-1:0] be);
    logic [W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (be[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  assign wa_addr1 = wa_addr_i ^ ADDR_W'(1);

  always_ff @(posedge clk_i) begin
    if (wa_vld_i) begin
      mem_q[wa_addr_i] <= lane_merge(mem_q[wa_addr_i], wa_d0_i, wa_be0_i);
      mem_q[wa_addr1]  <= lane_merge(mem_q[wa_addr1],  wa_d1_i, wa_be1_i);
    end
  end

  // read both beats; overlay the write that commits on this same edge
  for (genvar b = 0; b < 2; b++) begin : g_beat
    logic [ADDR_W-1:0] loc;
    assign loc = rd_addr_i ^ ADDR_W'(b);
    always_comb begin
      fwd[b] = mem_q[loc];
      if (wa_vld_i && loc == wa_addr_i) fwd[b] = lane_merge(fwd[b], wa_d0_i, wa_be0_i);
      if (wa_vld_i && loc == wa_addr1)  fwd[b] = lane_merge(fwd[b], wa_d1_i, wa_be1_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o <= 1'b0;
      rd_w0_o  <= '0;
      rd_w1_o  <= '0;
    end else begin
      rd_vld_o <= rd_req_i;
      if (rd_req_i) begin
        rd_w0_o <= fwd[0];
        rd_w1_o <= fwd[1];
      end
    end
  end

  AST_FWD_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_vld_i && rd_req_i && rd_addr_i == wa_addr_i && (&wa_be0_i))
      |=> (rd_w0_o == $past(wa_d0_i))); // R8
endmodule

// File: rtl/b2_rd_out.sv
`timescale 1ns/1ps
module b2_rd_out #(
  parameter int W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_vld_i,
  input  logic [W-1:0] rd_w0_i,
  input  logic [W-1:0] rd_w1_i,
  output logic         oe_o,
  output logic [W-1:0] rdata_o
);
  logic         neg_vld_q, pos_vld_q;
  logic [W-1:0] neg_w0_q, neg_w1_q, pos_w1_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_vld_q <= 1'b0;
      neg_w0_q  <= '0;
      neg_w1_q  <= '0;
    end else begin
      neg_vld_q <= rd_vld_i;
      neg_w0_q  <= rd_vld_i ? rd_w0_i : '0;
      neg_w1_q  <= rd_vld_i ? rd_w1_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_vld_q <= 1'b0;
      pos_w1_q  <= '0;
    end else begin
      pos_vld_q <= neg_vld_q;
      pos_w1_q  <= neg_w1_q;
    end
  end

  // double-data-rate launch: low phase beat 0, high phase beat 1
  assign oe_o    = clk_i ? pos_vld_q : neg_vld_q;
  assign rdata_o = clk_i ? pos_w1_q  : neg_w0_q;

  AST_BEAT_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_i |=> pos_vld_q); // R2
  AST_AUTO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_vld_i |=> !pos_vld_q); // R6
endmodule

// File: rtl/b2_sram_core.sv
`timescale 1ns/1ps
module b2_sram_core
  import b2_sram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_ni,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              oe_o
);
  op_e               op;
  logic [ADDR_W-1:0] cmd_addr;
  logic              wa_vld;
  logic [ADDR_W-1:0] wa_addr;
  logic [W-1:0]      wa_d0, wa_d1;
  logic [LANES-1:0]  wa_be0, wa_be1;
  logic              rd_vld;
  logic [W-1:0]      rd_w0, rd_w1;

  b2_cmd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cmd (
    .clk_i, .rst_ni, .ld_ni, .rw_i, .addr_i, .wdata_i, .wbe_i,
    .op_o(op), .cmd_addr_o(cmd_addr),
    .wa_vld_o(wa_vld), .wa_addr_o(wa_addr),
    .wa_d0_o(wa_d0), .wa_be0_o(wa_be0), .wa_d1_o(wa_d1), .wa_be1_o(wa_be1)
  );

  b2_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni,
    .wa_vld_i(wa_vld), .wa_addr_i(wa_addr),
    .wa_d0_i(wa_d0), .wa_be0_i(wa_be0), .wa_d1_i(wa_d1), .wa_be1_i(wa_be1),
    .rd_req_i(op == OP_READ), .rd_addr_i(cmd_addr),
    .rd_vld_o(rd_vld), .rd_w0_o(rd_w0), .rd_w1_o(rd_w1)
  );

  b2_rd_out #(.W(W)) u_out (
    .clk_i, .rst_ni,
    .rd_vld_i(rd_vld), .rd_w0_i(rd_w0), .rd_w1_i(rd_w1),
    .oe_o, .rdata_o
  );

  AST_QUIET_BUS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == '0)); // R6
  AST_RESET_OFF: assert property (@(negedge clk_i)
    !rst_ni |-> !oe_o); // R10
endmodule

// File: tb/tb_b2_sram_core.sv
`timescale 1ns/1ps
module tb_b2_sram_core;
  localparam int AW    = 5;
  localparam int L     = 4;
  localparam int LW    = 9;
  localparam int W     = L * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_ni = 1'b1;
  logic          rw_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [L-1:0]  wbe_i = '0;
  logic [W-1:0]  wdata_i = '0;
  logic [W-1:0]  rdata_o;
  logic          oe_o;

  b2_sram_core #(.ADDR_W(AW), .LANES(L), .LANE_W(LW)) dut (
    .clk_i, .rst_ni, .ld_ni, .rw_i, .addr_i, .wbe_i, .wdata_i, .rdata_o, .oe_o
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, n_step = 0;
  logic [W-1:0] mdl [DEPTH];

  // pending late-write beats and read history (h1: last step, h2: two steps ago)
  logic         pw_vld = 1'b0;
  logic [W-1:0] pw_d0 = '0, pw_d1 = '0;
  logic [L-1:0] pw_be0 = '0, pw_be1 = '0;
  logic         h1_vld = 1'b0, h2_vld = 1'b0;
  logic [W-1:0] h1_w0 = '0, h1_w1 = '0, h2_w0 = '0, h2_w1 = '0;
  string        h1_tag = "R6", h2_tag = "R6";

  function automatic logic [W-1:0] pat(input int loc, input int seed);
    logic [63:0] x;
    x = (64'(loc) + 64'd1) * 64'h9E3779B97F4A7C15 ^ (64'(seed) << 17) ^ (64'(seed) * 64'h1234567);
    return x[W-1:0];
  endfunction

  function automatic logic [W-1:0] mrg(input logic [W-1:0] o, input logic [W-1:0] n,
                                       input logic [L-1:0] be);
    logic [W-1:0] r;
    r = o;
    for (int i = 0; i < L; i++) if (be[i]) r[i*LW +: LW] = n[i*LW +: LW];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic phase_chk(input logic vld, input logic [W-1:0] w, input string tag);
    string t;
    t = vld ? tag : "R6";
    chk(t, W'(oe_o), W'(vld));
    chk(t, rdata_o, vld ? w : '0);
  endtask

  // one command cycle: drive before the rising edge, beat 1 data before the falling edge
  task automatic step(input logic ld_n, input logic rw, input int a,
                      input logic [W-1:0] d0, input logic [W-1:0] d1,
                      input logic [L-1:0] be0, input logic [L-1:0] be1, input string tag);
    logic [AW-1:0] ax;
    ax = AW'(a);
    @(negedge clk_i); #2;
    phase_chk(h2_vld, h2_w0, h2_tag);   // beat 0 of read from two steps back
    ld_ni = ld_n; rw_i = rw; addr_i = ax;
    wdata_i = pw_vld ? pw_d0 : pat(n_step, 99);
    wbe_i   = pw_vld ? pw_be0 : '1;
    @(posedge clk_i); #2;
    phase_chk(h2_vld, h2_w1, h2_tag);   // beat 1
    wdata_i = pw_vld ? pw_d1 : pat(n_step, 98);
    wbe_i   = pw_vld ? pw_be1 : '1;
    h2_vld = h1_vld; h2_w0 = h1_w0; h2_w1 = h1_w1; h2_tag = h1_tag;
    h1_vld = !ld_n && rw;
    h1_w0  = mdl[ax]; h1_w1 = mdl[ax ^ AW'(1)]; h1_tag = tag;
    pw_vld = !ld_n && !rw; pw_d0 = d0; pw_d1 = d1; pw_be0 = be0; pw_be1 = be1;
    if (!ld_n && !rw) begin
      mdl[ax]           = mrg(mdl[ax], d0, be0);
      mdl[ax ^ AW'(1)]  = mrg(mdl[ax ^ AW'(1)], d1, be1);
    end
    n_step++;
  endtask

  task automatic wr(input int a, input logic [W-1:0] d0, input logic [W-1:0] d1,
                    input logic [L-1:0] be0, input logic [L-1:0] be1);
    step(1'b0, 1'b0, a, d0, d1, be0, be1, "R3");
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, 1'b1, a, '0, '0, '0, '0, tag);
  endtask

  task automatic nop(input int a);
    step(1'b1, 1'b0, a, pat(a, 77), pat(a, 78), '1, '1, "R6");
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    // R10: outputs quiet in reset, both clock phases
    repeat (2) @(posedge clk_i);
    #2; chk("R10", W'(oe_o), '0); chk("R10", rdata_o, '0);
    @(negedge clk_i); #2; chk("R10", W'(oe_o), '0); chk("R10", rdata_o, '0);
    rst_ni = 1'b1;

    // R3/R4: fill every pair with back-to-back writes
    for (int a = 0; a < DEPTH; a += 2) wr(a, pat(a, 1), pat(a + 1, 1), '1, '1);
    // R9 even starts, R4 odd starts: continuous read stream
    for (int a = 0; a < DEPTH; a++) rd(a, (a % 2) ? "R4" : "R9");
    nop(0); nop(0);

    // R4: write with odd start address, beat 1 lands on the even location
    for (int a = 1; a < DEPTH; a += 4) wr(a, pat(a, 3), pat(a, 4), '1, '1);
    for (int a = 0; a < DEPTH; a += 4) rd(a, "R4");

    // R5: idle cycles after a read carry junk and must not disturb it
    for (int a = 0; a < DEPTH; a += 7) begin
      rd(a, "R5");
      nop(a + 3); nop(a + 5); nop(a + 1);
    end

    // R1: junk with load high (rw low), then whole array must be unchanged
    for (int a = 0; a < 8; a++) nop(a * 3);
    for (int a = 0; a < DEPTH; a++) rd(a, "R1");
    nop(0); nop(0);

    // R7: every lane pattern, opposite pattern on beat 1
    for (int p = 0; p < (1 << L); p++) begin
      int a;
      a = (p * 2) % DEPTH;
      wr(a, pat(a, 10 + p), pat(a + 1, 10 + p), L'(p), ~L'(p));
      nop(a);
      rd(a, "R7");
    end
    nop(0); nop(0);

    // R8: read right after write, same, swapped and partial overlap
    for (int a = 0; a < DEPTH; a += 5) begin
      wr(a, pat(a, 40), pat(a, 41), '1, '1);
      rd(a, "R8");
      wr(a, pat(a, 42), pat(a, 43), L'(5), L'(10));
      rd(a ^ 1, "R8");
    end
    nop(0); nop(0);

    // R2: isolated reads, each with idle bus around it
    for (int a = 3; a < DEPTH; a += 9) begin
      rd(a, "R2");
      nop(0); nop(0); nop(0);
    end
    // R9: alternating writes and reads keep forwarding and latency aligned
    for (int a = 0; a < 8; a++) begin
      wr(a, pat(a, 60), pat(a, 61), '1, '1);
      rd(a + 8, "R9");
    end
    nop(0); nop(0); nop(0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule